// File: doc/BRIEF.md
# Toggle-On-Write Interrupt Register Unit

This unit collects interrupt events from a peripheral with several independent serial ports (two by default) and drives one level-sensitive interrupt line towards a processor. Each port supplies a one-cycle event pulse. The pulse is captured in that port's pending bit, masked by that port's enable bit, and the masked bits are combined. The result is then gated by a single master enable before it reaches the registered output.

Software reaches the unit through a simple synchronous register bus. It can read and write three words: the master enable at offset 0x00, the pending register at offset 0x04 and the per-port enable register at offset 0x08.

Pending bits are cleared by toggling them rather than by read-modify-write. A write flips exactly the bits written as 1, so an event that lands between a read and the following write survives.

Top module: `irq_tow_unit`

## Requirements
- R1: After reset (and after any later reset) the master enable, every pending bit and every enable bit are 0, and `irq_o` is 0.
- R2: An event pulse on `evt_i[i]` sets pending bit i, which reads back as bit i of offset 0x04 in the cycle after the pulse.
- R3: A write to offset 0x04 inverts every pending bit whose write-data bit is 1 and leaves bits written 0 unchanged; without such a write or an event, pending bits hold.
- R4: When an event pulse and a toggle write hit the same pending bit in one cycle, the bit ends up set.
- R5: Offset 0x08 holds one read/write enable bit per port in bits [NUM_PORTS-1:0]; writing it never changes the pending bits.
- R6: The master enable is bit 0 of offset 0x00; bits [31:1] of that word read as 0 and writes to them have no effect.
- R7: `irq_o` equals master enable AND the OR over ports of (pending AND enable), taken from the register state one clock earlier.
- R8: With the master enable at 0, `irq_o` is 0 regardless of pending and enable bits.
- R9: Writes to offsets other than 0x00, 0x04 and 0x08 change nothing; reads of such offsets, and of unused bits of mapped words, return 0.
- R10: A toggle write clears only the bits written as 1, so an event captured on another port after software read the pending word stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | NUM_PORTS | One-cycle event pulse per port |
| bus_sel_i | input | 1 | Register access in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the word |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, combinational from current registers during a read, else 0 |
| irq_o | output | 1 | Level interrupt to the processor |

## Verification
A write or event at clock edge N is visible on a read in the cycle that follows edge N, because read data is combinational. `irq_o` passes through one more register and changes only at edge N+1. For each step the bench drives the stimulus for one cycle and then reads back the affected word just after the next falling edge. It compares `irq_o` only after the following rising edge, while the bus is idle and no event is driven. This makes every comparison land in the cycle where the result is due.

// File: rtl/irq_tow_pkg.sv
// Package: shared widths and register offsets for the toggle-on-write
// interrupt unit. Assumes a 32-bit data path and byte-addressed words.
package irq_tow_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 8;

    // Word offsets; software depends on these positions.
    localparam logic [ADDR_W-1:0] OFF_MASTER = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_PEND   = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_ENABLE = 8'h08;

    // Index of each decoded register in the one-hot hit vectors.
    typedef enum logic [1:0] {
        REG_MASTER = 2'd0,
        REG_PEND   = 2'd1,
        REG_ENABLE = 2'd2
    } reg_idx_e;

    localparam int unsigned NUM_REGS = 3;

endpackage

// File: rtl/irq_tow_decode.sv
// Module: address decoder. Turns one bus access into one-hot write and
// read strobes per mapped register. Unmapped offsets produce no strobe.
// Assumes the access lasts exactly the cycle in which bus_sel_i is high.
module irq_tow_decode
    import irq_tow_pkg::*;
(
    input  logic                bus_sel_i,
    input  logic                bus_wr_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    output logic [NUM_REGS-1:0] wr_hit_o,
    output logic [NUM_REGS-1:0] rd_hit_o
);

    logic [NUM_REGS-1:0] addr_match;

    // Compare the offset against each mapped word.
    always_comb begin
        addr_match                     = '0;
        addr_match[int'(REG_MASTER)]   = (bus_addr_i == OFF_MASTER);
        addr_match[int'(REG_PEND)]     = (bus_addr_i == OFF_PEND);
        addr_match[int'(REG_ENABLE)]   = (bus_addr_i == OFF_ENABLE);
    end

    // Qualify the matches with the access type.
    always_comb begin
        wr_hit_o = (bus_sel_i &&  bus_wr_i) ? addr_match : '0;
        rd_hit_o = (bus_sel_i && !bus_wr_i) ? addr_match : '0;
    end

endmodule

// File: rtl/irq_tow_pending.sv
// Module: per-port pending bits. An event sets its bit; a toggle write
// inverts the bits written as 1. When both touch one bit in the same
// cycle, the event wins. Assumes events are single-cycle pulses.
module irq_tow_pending #(
    parameter int unsigned NUM_PORTS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] evt_i,
    input  logic                 tog_en_i,
    input  logic [NUM_PORTS-1:0] tog_mask_i,
    output logic [NUM_PORTS-1:0] pend_o
);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic bit_q;
        logic bit_d;

        // Next value: toggle if requested, then force set on an event.
        always_comb begin
            bit_d = bit_q ^ (tog_en_i & tog_mask_i[p]);
            if (evt_i[p]) begin
                bit_d = 1'b1;
            end
        end

        // Pending flop with synchronous active-low reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else begin
                bit_q <= bit_d;
            end
        end

        assign pend_o[p] = bit_q;
    end

endmodule

// File: rtl/irq_tow_ctrl.sv
// Module: master enable and per-port enable registers. Both are plain
// read/write storage. Only bit 0 of the master word and the low NUM_PORTS
// bits of the enable word are kept.
module irq_tow_ctrl #(
    parameter int unsigned NUM_PORTS = 2,
    parameter int unsigned DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 master_wr_i,
    input  logic                 enable_wr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic                 master_o,
    output logic [NUM_PORTS-1:0] enable_o
);

    // Master enable flop, bit 0 of its word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_o <= 1'b0;
        end else if (master_wr_i) begin
            master_o <= wdata_i[0];
        end
    end

    // Per-port enable flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_o <= '0;
        end else if (enable_wr_i) begin
            enable_o <= wdata_i[NUM_PORTS-1:0];
        end
    end

endmodule

// File: rtl/irq_tow_output.sv
// Module: interrupt combiner. ANDs the pending and enable bits, ORs the
// results, gates them with the master enable and registers the result.
// The output therefore lags the register state by one clock.
module irq_tow_output #(
    parameter int unsigned NUM_PORTS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 master_i,
    input  logic [NUM_PORTS-1:0] pend_i,
    input  logic [NUM_PORTS-1:0] enable_i,
    output logic                 irq_o
);

    logic any_active;

    // Reduce the masked pending bits.
    always_comb begin
        any_active = |(pend_i & enable_i);
    end

    // Output register, gated by the master enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
        end else begin
            irq_o <= master_i & any_active;
        end
    end

endmodule

// File: rtl/irq_tow_unit.sv
// Module: top of the toggle-on-write interrupt unit. Decodes the register
// bus, holds the pending, enable and master registers, and drives one
// level interrupt. Read data is combinational and is 0 outside a read.
// Assumes a synchronous bus where each access lasts one cycle.
module irq_tow_unit
    import irq_tow_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PORTS-1:0] evt_i,
    input  logic                 bus_sel_i,
    input  logic                 bus_wr_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [DATA_W-1:0]    bus_wdata_i,
    output logic [DATA_W-1:0]    bus_rdata_o,
    output logic                 irq_o
);

    logic [NUM_REGS-1:0]  wr_hit;
    logic [NUM_REGS-1:0]  rd_hit;
    logic [NUM_PORTS-1:0] pend_q;
    logic [NUM_PORTS-1:0] enable_q;
    logic                 master_q;

    irq_tow_decode u_decode (
        .bus_sel_i  (bus_sel_i),
        .bus_wr_i   (bus_wr_i),
        .bus_addr_i (bus_addr_i),
        .wr_hit_o   (wr_hit),
        .rd_hit_o   (rd_hit)
    );

    irq_tow_pending #(.NUM_PORTS(NUM_PORTS)) u_pending (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .tog_en_i   (wr_hit[int'(REG_PEND)]),
        .tog_mask_i (bus_wdata_i[NUM_PORTS-1:0]),
        .pend_o     (pend_q)
    );

    irq_tow_ctrl #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_wr_i (wr_hit[int'(REG_MASTER)]),
        .enable_wr_i (wr_hit[int'(REG_ENABLE)]),
        .wdata_i     (bus_wdata_i),
        .master_o    (master_q),
        .enable_o    (enable_q)
    );

    irq_tow_output #(.NUM_PORTS(NUM_PORTS)) u_output (
        .clk      (clk),
        .rst_n    (rst_n),
        .master_i (master_q),
        .pend_i   (pend_q),
        .enable_i (enable_q),
        .irq_o    (irq_o)
    );

    // Read mux: unused bits and unmapped offsets return zero.
    always_comb begin
        bus_rdata_o = '0;
        if (rd_hit[int'(REG_MASTER)]) begin
            bus_rdata_o[0] = master_q;
        end
        if (rd_hit[int'(REG_PEND)]) begin
            bus_rdata_o[NUM_PORTS-1:0] = pend_q;
        end
        if (rd_hit[int'(REG_ENABLE)]) begin
            bus_rdata_o[NUM_PORTS-1:0] = enable_q;
        end
    end

endmodule

// File: rtl/irq_tow_checker.sv
// Module: assertion checker for irq_tow_unit, attached by bind. It watches
// the ports and the internal registers and checks them against the stated
// timing relations.
module irq_tow_checker
    import irq_tow_pkg::*;
#(
    parameter int unsigned NUM_PORTS = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_PORTS-1:0] evt_i,
    input logic                 bus_sel_i,
    input logic                 bus_wr_i,
    input logic [ADDR_W-1:0]    bus_addr_i,
    input logic [DATA_W-1:0]    bus_rdata_o,
    input logic                 irq_o,
    input logic [NUM_PORTS-1:0] pend_q,
    input logic [NUM_PORTS-1:0] enable_q,
    input logic                 master_q
);

    logic pend_wr;
    assign pend_wr = bus_sel_i && bus_wr_i && (bus_addr_i == OFF_PEND);

    // R2 and R4: every pulsed port is pending one cycle later.
    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((pend_q & $past(evt_i)) == $past(evt_i)));

    // R3: pending bits hold without a toggle write or an event.
    assert_pend_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_wr && evt_i == '0) |=> $stable(pend_q));

    // R7: the output follows the gated, masked state one cycle late.
    assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (master_q && ((pend_q & enable_q) != '0)) |=> irq_o);

    // R8: a cleared master enable forces the output low.
    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !master_q |=> !irq_o);

    // R6 and R9: unused read bits of the master word stay zero.
    assert_master_unused_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel_i && !bus_wr_i && bus_addr_i == OFF_MASTER)
            |-> (bus_rdata_o[DATA_W-1:1] == '0));

    // R9: nothing is returned outside a read access.
    assert_idle_rdata_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel_i && !bus_wr_i) |-> (bus_rdata_o == '0));

endmodule

bind irq_tow_unit irq_tow_checker #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt_i       (evt_i),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_rdata_o (bus_rdata_o),
    .irq_o       (irq_o),
    .pend_q      (pend_q),
    .enable_q    (enable_q),
    .master_q    (master_q)
);

// File: tb/irq_tow_unit_tb.sv
`timescale 1ns/1ps
module irq_tow_unit_tb;

    localparam int NP = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] evt = '0;
    logic          sel = 1'b0;
    logic          wr = 1'b0;
    logic [7:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    irq_tow_unit #(.NUM_PORTS(NP)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt),
        .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
    );

    typedef struct packed {
        logic        do_wr;
        logic [7:0]  waddr;
        logic [31:0] wval;
        logic [1:0]  ev;
        logic [7:0]  raddr;
        logic [31:0] exp_rd;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h08, 32'h3,        2'b00, 8'h08, 32'h3, 1'b0}, // R5 enable write
        '{1'b0, 8'h00, 32'h0,        2'b01, 8'h04, 32'h1, 1'b0}, // R2, R8 master off
        '{1'b1, 8'h00, 32'hFFFFFFFF, 2'b00, 8'h00, 32'h1, 1'b1}, // R6, R7
        '{1'b0, 8'h00, 32'h0,        2'b10, 8'h04, 32'h3, 1'b1}, // R2 port 1
        '{1'b1, 8'h04, 32'h1,        2'b00, 8'h04, 32'h2, 1'b1}, // R3, R10
        '{1'b1, 8'h08, 32'h1,        2'b00, 8'h04, 32'h2, 1'b0}, // R5, R7 masked
        '{1'b1, 8'h0C, 32'hFFFFFFFF, 2'b00, 8'h0C, 32'h0, 1'b0}, // R9 unmapped
        '{1'b0, 8'h00, 32'h0,        2'b00, 8'h08, 32'h1, 1'b0}, // R9 enable kept
        '{1'b1, 8'h04, 32'h2,        2'b00, 8'h04, 32'h0, 1'b0}, // R3 clear
        '{1'b1, 8'h04, 32'h3,        2'b00, 8'h04, 32'h3, 1'b1}, // R3 toggle sets
        '{1'b1, 8'h00, 32'h0,        2'b00, 8'h00, 32'h0, 1'b0}, // R8 master off
        '{1'b1, 8'h00, 32'h2,        2'b00, 8'h00, 32'h0, 1'b0}, // R6 bit 1 ignored
        '{1'b1, 8'h08, 32'hFFFFFFFC, 2'b00, 8'h08, 32'h0, 1'b0}  // R9 unused bits
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One-cycle write (optional) plus events, starting at a falling edge.
    task automatic drive(input logic dw, input logic [7:0] a, input logic [31:0] d,
                         input logic [NP-1:0] e);
        sel = dw; wr = dw; addr = a; wdata = d; evt = e;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; wdata = '0; evt = '0;
    endtask

    // Read at the current falling edge; sample after settling.
    task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        sel = 1'b1; wr = 1'b0; addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    // Let the output register take one edge, then compare it.
    task automatic irq_chk(input string req, input logic exp);
        @(negedge clk);
        sel = 1'b0;
        check(req, {31'b0, irq}, {31'b0, exp});
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd("R1 master", 8'h00, 32'h0);
        rd("R1 pending", 8'h04, 32'h0);
        rd("R1 enable", 8'h08, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        @(negedge clk);
        sel = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].do_wr, VECS[i].waddr, VECS[i].wval, VECS[i].ev);
            rd($sformatf("vector %0d rdata", i), VECS[i].raddr, VECS[i].exp_rd);
            irq_chk($sformatf("vector %0d irq", i), VECS[i].exp_irq);
        end

        // State now: master 0, enable 0, pending 3.
        drive(1'b1, 8'h00, 32'h1, '0);
        drive(1'b1, 8'h08, 32'h3, '0);
        // R4: toggle and event on port 0 together; event wins.
        drive(1'b1, 8'h04, 32'h1, 2'b01);
        rd("R4 event wins", 8'h04, 32'h3);
        irq_chk("R4 irq", 1'b1);
        // R4: event on port 1 while port 0 toggles off.
        drive(1'b1, 8'h04, 32'h3, 2'b10);
        rd("R4 mixed", 8'h04, 32'h2);
        irq_chk("R4 irq mixed", 1'b1);

        // R10: read, then an event arrives, then software clears only port 1.
        rd("R10 read before", 8'h04, 32'h2);
        @(negedge clk);
        drive(1'b0, 8'h00, 32'h0, 2'b01);
        drive(1'b1, 8'h04, 32'h2, '0);
        rd("R10 late event kept", 8'h04, 32'h1);
        irq_chk("R10 irq", 1'b1);

        // R7: clearing the last pending bit drops the output one edge later.
        drive(1'b1, 8'h04, 32'h1, '0);
        check("R7 irq still high", {31'b0, irq}, 32'h1);
        irq_chk("R7 irq low", 1'b0);

        // R1: reset in mid-run clears everything.
        drive(1'b0, 8'h00, 32'h0, 2'b11);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd("R1 master again", 8'h00, 32'h0);
        rd("R1 pending again", 8'h04, 32'h0);
        rd("R1 enable again", 8'h08, 32'h0);
        check("R1 irq again", {31'b0, irq}, 32'h0);
        @(negedge clk);
        sel = 1'b0;

        finish_run();
    end

endmodule